// File: doc/BRIEF.md
# LCD dot clock generator

This block derives the pixel-rate timing for a display controller from one of two source clocks. All timing is carried as single-cycle enable strobes in one system clock domain. One source arrives as a peripheral-rate strobe and the other as an external-rate strobe. A 16-bit control register picks the source and a division ratio. The block counts strobes of the chosen source and emits a one-cycle dot enable once per programmed ratio.

A second enable, the panel shift enable, follows the dot enable. For an active-matrix panel it fires on every dot enable. For a passive-matrix panel, single or dual scan, it fires once per panel-bus-width dot enables. Panel type and bus width are static configuration inputs.

The divider is a two-state machine. In `DIV_RUN` it counts strobes of the selected source and reloads its ratio at each dot boundary. In `DIV_HALT` it produces no dot enables while the source code is a prohibited value. It moves from `DIV_RUN` to `DIV_HALT` on the first clock edge that sees a prohibited code. It moves from `DIV_HALT` to `DIV_RUN` on the first edge that sees a legal code. On that edge it clears its strobe count, loads the current ratio and ignores the strobe.

Top module: `lcd_dotclk_gen`

## Requirements
- R1: After reset the register reads 0x1101: source code 01 (peripheral strobe) in bits 13:12, ratio 1 in bits 5:0.
- R2: Bits 15:14, 11:9 and 7:6 always read 0 and bit 8 always reads 1, whatever is written. For example, writing 0xFFFF reads back 0x313F and writing 0x0000 reads back 0x0100.
- R3: Source code 01 counts only `src_periph_en`. Code 10 counts only `src_ext_en`. Strobes on the other input have no effect on `dot_en`.
- R4: With ratio N from 1 to 32, `dot_en` pulses for one cycle after every Nth counted strobe, in the cycle after the clock edge that sampled that strobe.
- R5: A ratio field of 0, or of 33 to 63, divides by 32.
- R6: While the source code is 00 or 11, `dot_en` stays low. Counting restarts from zero once a legal code is written, and the strobe on the resuming edge is not counted.
- R7: A new ratio is loaded only at a dot boundary (the edge that raises `dot_en`) or on leaving `DIV_HALT`. The period in progress completes with the old ratio.
- R8: With `panel_passive` low, `shift_en` equals `dot_en` in every cycle.
- R9: With `panel_passive` high, `shift_en` pulses together with every Wth `dot_en`, where W is 4, 8 or 16 for `bus_width_sel` 00, 01, or 10/11.
- R10: A write with `reg_wr` high at a clock edge updates the source and ratio fields, and `reg_rdata` shows the new value from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data |
| src_periph_en | input | 1 | Peripheral-rate source strobe |
| src_ext_en | input | 1 | External-rate source strobe |
| panel_passive | input | 1 | 1 = passive-matrix panel, 0 = active-matrix |
| bus_width_sel | input | 2 | Panel bus width: 00=4, 01=8, 10/11=16 |
| dot_en | output | 1 | Dot clock enable |
| shift_en | output | 1 | Panel shift clock enable |

## Verification
The bench builds the block with its default parameters: a maximum ratio of 32 and a six-bit ratio field. These values make every clamp case reachable through the register, namely zero, 32 itself and values up to 63. The largest panel width of 16 means one shift period spans at most 16 × 32 source strobes, so every passive width completes several shift periods within a short run. A reference model in the bench predicts both enables from sparse, dense and irregular strobe patterns. The predictions cover changes of ratio in mid-period and round trips through both prohibited codes.

// File: rtl/dcg_pkg.sv
package dcg_pkg;

    typedef enum logic [1:0] {
        SRC_BAD0   = 2'b00,
        SRC_PERIPH = 2'b01,
        SRC_EXT    = 2'b10,
        SRC_BAD3   = 2'b11
    } src_sel_e;

    typedef enum logic {
        DIV_RUN  = 1'b0,
        DIV_HALT = 1'b1
    } div_state_e;

    function automatic logic src_legal(input logic [1:0] code);
        return (code == SRC_PERIPH) || (code == SRC_EXT);
    endfunction

endpackage

// File: rtl/dcg_ctrl_reg.sv
module dcg_ctrl_reg
    import dcg_pkg::*;
#(
    parameter int RATIO_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [15:0]        wdata,
    output logic [1:0]         sel_o,
    output logic [RATIO_W-1:0] ratio_o,
    output logic [15:0]        rdata
);

    localparam int SEL_LSB  = 12;
    localparam int FIXED_HI = 8;

    logic [1:0]         sel_q;
    logic [RATIO_W-1:0] ratio_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q   <= SRC_PERIPH;
            ratio_q <= RATIO_W'(1);
        end else if (wr) begin
            sel_q   <= wdata[SEL_LSB+1:SEL_LSB];
            ratio_q <= wdata[RATIO_W-1:0];
        end
    end

    always_comb begin
        rdata                     = '0;
        rdata[SEL_LSB+1:SEL_LSB]  = sel_q;
        rdata[FIXED_HI]           = 1'b1;
        rdata[RATIO_W-1:0]        = ratio_q;
    end

    assign sel_o   = sel_q;
    assign ratio_o = ratio_q;

    // R10: a write lands in the fields on the following cycle
    a_r10_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (sel_q == $past(wdata[SEL_LSB+1:SEL_LSB])) && (ratio_q == $past(wdata[RATIO_W-1:0])));

endmodule

// File: rtl/dcg_divider.sv
module dcg_divider
    import dcg_pkg::*;
#(
    parameter int RATIO_W = 6,
    parameter int DIV_MAX = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         sel,
    input  logic [RATIO_W-1:0] ratio,
    input  logic               strobe,
    output logic               dot_o
);

    localparam int CNT_W = $clog2(DIV_MAX);
    localparam int DIV_W = CNT_W + 1;
    localparam logic [RATIO_W-1:0] MAX_R = RATIO_W'(DIV_MAX);

    div_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [DIV_W-1:0] cur_div_q;
    logic             dot_q;
    logic             legal;

    function automatic logic [DIV_W-1:0] eff_div(input logic [RATIO_W-1:0] r);
        if (r == '0 || r > MAX_R) return MAX_R[DIV_W-1:0];
        return r[DIV_W-1:0];
    endfunction

    assign legal = src_legal(sel);

    always_comb begin
        state_d = legal ? DIV_RUN : DIV_HALT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DIV_RUN;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            cur_div_q <= DIV_W'(1);
            dot_q     <= 1'b0;
        end else begin
            dot_q <= 1'b0;
            unique case (state_q)
                DIV_HALT: begin
                    cnt_q <= '0;
                    if (legal) cur_div_q <= eff_div(ratio);
                end
                DIV_RUN: begin
                    if (!legal) begin
                        cnt_q <= '0;
                    end else if (strobe) begin
                        if ({1'b0, cnt_q} == cur_div_q - DIV_W'(1)) begin
                            dot_q     <= 1'b1;
                            cnt_q     <= '0;
                            cur_div_q <= eff_div(ratio);
                        end else begin
                            cnt_q <= cnt_q + CNT_W'(1);
                        end
                    end
                end
            endcase
        end
    end

    assign dot_o = dot_q;

    // R4: the strobe count never reaches the active ratio
    a_r4_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DIV_RUN) |-> ({1'b0, cnt_q} < cur_div_q));

    // R6: a prohibited code silences the next cycle
    a_r6_halt_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !legal |=> !dot_q);

    // R7: ratio reload only at a dot boundary while running
    a_r7_div_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DIV_RUN && $past(state_q) == DIV_RUN && cur_div_q != $past(cur_div_q)) |-> dot_q);

endmodule

// File: rtl/dcg_shift.sv
module dcg_shift #(
    parameter int MAX_BUS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dot,
    input  logic       passive,
    input  logic [1:0] width_sel,
    output logic       shift_o
);

    localparam int SC_W = $clog2(MAX_BUS);

    logic [SC_W-1:0] sc_q;
    logic [SC_W-1:0] last;

    always_comb begin
        unique case (width_sel)
            2'b00:   last = SC_W'(3);
            2'b01:   last = SC_W'(7);
            default: last = SC_W'(MAX_BUS - 1);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   sc_q <= '0;
        else if (dot) sc_q <= (sc_q >= last) ? '0 : sc_q + SC_W'(1);
    end

    assign shift_o = dot && (!passive || sc_q == last);

    // R9: a shift pulse is always a dot pulse too
    a_r9_shift_needs_dot: assert property (@(posedge clk) disable iff (!rst_n)
        shift_o |-> dot);

endmodule

// File: rtl/lcd_dotclk_gen.sv
module lcd_dotclk_gen
    import dcg_pkg::*;
#(
    parameter int RATIO_W = 6,
    parameter int DIV_MAX = 32,
    parameter int MAX_BUS = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    input  logic        src_periph_en,
    input  logic        src_ext_en,
    input  logic        panel_passive,
    input  logic [1:0]  bus_width_sel,
    output logic        dot_en,
    output logic        shift_en
);

    logic [1:0]         sel;
    logic [RATIO_W-1:0] ratio;
    logic               src_strobe;

    dcg_ctrl_reg #(.RATIO_W(RATIO_W)) u_reg (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wdata(reg_wdata),
        .sel_o(sel), .ratio_o(ratio), .rdata(reg_rdata)
    );

    assign src_strobe = (sel == SRC_EXT) ? src_ext_en : src_periph_en;

    dcg_divider #(.RATIO_W(RATIO_W), .DIV_MAX(DIV_MAX)) u_div (
        .clk(clk), .rst_n(rst_n), .sel(sel), .ratio(ratio),
        .strobe(src_strobe), .dot_o(dot_en)
    );

    dcg_shift #(.MAX_BUS(MAX_BUS)) u_shift (
        .clk(clk), .rst_n(rst_n), .dot(dot_en), .passive(panel_passive),
        .width_sel(bus_width_sel), .shift_o(shift_en)
    );

    // R8: active panels shift on every dot
    a_r8_active_shift_eq_dot: assert property (@(posedge clk) disable iff (!rst_n)
        !panel_passive |-> (shift_en == dot_en));

    // R3: every dot follows a strobe of the selected source
    a_r3_dot_from_source: assert property (@(posedge clk) disable iff (!rst_n)
        dot_en |-> $past(src_strobe));

endmodule

// File: tb/test_lcd_dotclk_gen.sv
module test_lcd_dotclk_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        src_periph_en = 1'b0;
    logic        src_ext_en = 1'b0;
    logic        panel_passive = 1'b0;
    logic [1:0]  bus_width_sel = 2'b00;
    logic        dot_en, shift_en;

    int n_checks = 0;
    int n_fail   = 0;
    int dot_seen = 0;
    int shift_seen = 0;
    bit done = 1'b0;

    lcd_dotclk_gen i_lcd_dotclk_gen (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .src_periph_en(src_periph_en), .src_ext_en(src_ext_en),
        .panel_passive(panel_passive), .bus_width_sel(bus_width_sel),
        .dot_en(dot_en), .shift_en(shift_en)
    );

    always #10 clk = ~clk;

    // reference model state, built from the requirements
    logic [1:0] m_sel;
    logic [5:0] m_ratio;
    bit         m_run, m_dot;
    int         m_cnt, m_div, m_sc;
    logic [1:0] exp_q[$];

    function automatic int clamp_div(input logic [5:0] r);
        return (r == 0 || r > 32) ? 32 : int'(r);
    endfunction

    function automatic int width_of(input logic [1:0] w);
        return (w == 2'b00) ? 4 : (w == 2'b01) ? 8 : 16;
    endfunction

    always @(posedge clk) begin
        bit nd, strb, legal;
        if (!rst_n) begin
            m_sel = 2'b01; m_ratio = 6'd1; m_run = 1; m_cnt = 0; m_div = 1;
            m_sc = 0; m_dot = 0;
            exp_q.push_back(2'b00);
        end else begin
            if (m_dot) m_sc = (m_sc >= width_of(bus_width_sel) - 1) ? 0 : m_sc + 1;
            nd = 0;
            legal = (m_sel == 2'b01) || (m_sel == 2'b10);
            if (!legal) begin
                m_run = 0; m_cnt = 0;
            end else if (!m_run) begin
                m_run = 1; m_cnt = 0; m_div = clamp_div(m_ratio);
            end else begin
                strb = (m_sel == 2'b10) ? src_ext_en : src_periph_en;
                if (strb) begin
                    if (m_cnt == m_div - 1) begin
                        nd = 1; m_cnt = 0; m_div = clamp_div(m_ratio);
                    end else m_cnt++;
                end
            end
            if (reg_wr) begin
                m_sel = reg_wdata[13:12]; m_ratio = reg_wdata[5:0];
            end
            m_dot = nd;
            exp_q.push_back({nd, nd && (!panel_passive || m_sc == width_of(bus_width_sel) - 1)});
        end
    end

    // monitor: pops one expectation per cycle and compares (R3 R4 R5 R6 R7 R8 R9)
    always @(negedge clk) begin
        logic [1:0] e;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            n_checks++;
            if (dot_en !== e[1] || shift_en !== e[0]) begin
                n_fail++;
                $display("FAIL R4 R9 enables at %0t: actual dot=%b shift=%b expected dot=%b shift=%b",
                         $time, dot_en, shift_en, e[1], e[0]);
            end
            if (dot_en) dot_seen++;
            if (shift_en) shift_seen++;
        end
    end

    task automatic check_val(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [15:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // mode: 0 off, 1 every cycle, 2 irregular
    task automatic drive(input int cycles, input int pmode, input int emode);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            src_periph_en = (pmode == 1) || (pmode == 2 && ($urandom % 3 != 0));
            src_ext_en    = (emode == 1) || (emode == 2 && ($urandom % 2 == 0));
        end
        @(negedge clk);
        src_periph_en = 1'b0; src_ext_en = 1'b0;
    endtask

    task automatic do_reset(input bit passive, input logic [1:0] w);
        @(negedge clk);
        rst_n = 1'b0; panel_passive = passive; bus_width_sel = w;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #200_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_val("R1 reset value", int'(reg_rdata), 'h1101);

        // R4 R8 divide-by-1 then by 3 on the peripheral strobe
        drive(40, 1, 0);
        wr_reg(16'h1003);
        @(negedge clk);
        check_val("R10 readback", int'(reg_rdata), 'h1103);
        drive(120, 2, 2);

        // R7 ratio change while a period is in progress
        wr_reg(16'h1005);
        drive(7, 1, 0);
        wr_reg(16'h1002);
        drive(60, 2, 0);

        // R3 external source selected: peripheral strobes ignored
        wr_reg(16'h2007);
        repeat (3) @(negedge clk);
        dot_seen = 0;
        drive(80, 1, 0);
        check_val("R3 ignored source", dot_seen, 0);
        drive(150, 2, 1);
        check_val("R3 external source counted", int'(dot_seen > 0), 1);

        // R5 clamp of 0 and 40 to 32
        wr_reg(16'h1000);
        drive(200, 1, 0);
        wr_reg(16'h1028);
        dot_seen = 0;
        drive(330, 1, 0);
        check_val("R5 clamp count", int'(dot_seen >= 10 && dot_seen <= 11), 1);
        wr_reg(16'h1020);
        drive(100, 2, 0);

        // R6 prohibited codes halt output
        wr_reg(16'h0004);
        @(negedge clk);
        dot_seen = 0;
        drive(100, 1, 1);
        check_val("R6 halt code 00", dot_seen, 0);
        wr_reg(16'h3004);
        dot_seen = 0;
        drive(100, 1, 1);
        check_val("R6 halt code 11", dot_seen, 0);
        wr_reg(16'h1004);
        drive(60, 1, 0);
        check_val("R6 resume", int'(dot_seen > 0), 1);

        // R2 fixed bits
        wr_reg(16'hFFFF);
        @(negedge clk);
        check_val("R2 all ones", int'(reg_rdata), 'h313F);
        wr_reg(16'h0000);
        @(negedge clk);
        check_val("R2 all zeros", int'(reg_rdata), 'h0100);

        // R9 passive panels for each width code
        for (int w = 0; w < 4; w++) begin
            do_reset(1'b1, 2'(w));
            wr_reg(16'h1002);
            shift_seen = 0;
            dot_seen = 0;
            drive(400, 1, 0);
            check_val("R9 shift ratio", shift_seen, dot_seen / width_of(2'(w)));
        end

        // R8 active panel after reset, irregular strobes
        do_reset(1'b0, 2'b01);
        drive(150, 2, 0);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule